// File: doc/BRIEF.md
# Repeated Access Sequence Detector

This block watches a stream of memory operations, each an address plus a read/write command. It cuts the stream into short windows and files each window in a small hash-indexed table. It counts how many times in a row the same window comes back. When that count reaches a programmable threshold, the entry is marked learned and a one-cycle learn pulse carries the entry's 16-bit identifier. From then on, whenever the opening operations of a new window equal the opening of a learned entry, a one-cycle replay-start pulse with that identifier tells a downstream replay engine that it may take over.

Hash collisions are settled by a full-key comparator, so two different windows never share a count. A learned entry is never overwritten. A candidate that maps onto a learned slot is dropped and counted as a miss. Every entry has an idle timer. An entry that sees neither a training update nor a replay-start hit for a programmable number of cycles is freed.

Operations arrive on a valid/ready interface. The block never applies back-pressure: `in_ready` is high on every cycle outside reset. An operation is taken on a rising edge where both `in_valid` and `in_ready` are high, and address, command and end flag are ignored on every other edge. The configuration pins are plain levels and should be held steady while operations flow.

Top module: `rpt_seq_detector`

## Requirements
- R1: `in_ready` is high whenever reset is low, and only edges with `in_valid` high take an operation. Taken operations fill a window of up to 4 elements, and the window closes on its 4th operation or on an operation with `in_last` high.
- R2: A closed window whose length is below `cfg_min_len` creates and updates no entry. It also breaks any back-to-back run, so the next matching window starts again at count 1.
- R3: Two windows are the same only when their lengths match and every element matches in both address and command, where command 0 is read and 1 is write. A window with the same opening but a different length or command is a different sequence.
- R4: Each entry keeps an 8-bit repetition count. A window that matches the window closed just before it raises the count by one, saturating at 255. When the count reaches `cfg_threshold`, where 0 acts as 1, the entry becomes learned. `learn_valid` is then high for one cycle, two rising edges after the edge that took the window's last operation, with `learn_id` set to the entry's identifier.
- R5: If the window closed just before differs, a matching entry's count restarts at 1.
- R6: The slot index is the XOR of all 3-bit slices of the key {length[2:0], e3, e2, e1, e0}, zero-extended to 72 bits. Each element is e = {cmd, addr[15:0]}, e0 is the first operation and unused elements are zero. A key that lands on a non-learned entry holding a different key replaces it with a fresh entry at count 1.
- R7: A key that lands on a learned entry holding a different key is dropped and `miss_count` goes up by one. The learned entry stays intact and keeps triggering.
- R8: When the 2nd operation of a window is taken and the first two elements equal the first two of a learned entry of length 2 or more, `go_valid` is high for one cycle on the next cycle with that entry's `go_id`. The lowest slot wins.
- R9: Each valid entry's idle timer counts clock cycles. When it reaches `cfg_idle`, the entry is freed and stops triggering, and a later window may claim the slot. A `cfg_idle` of 0 disables this.
- R10: A replay-start hit or a training update on an entry clears its idle timer.
- R11: Synchronous active-high reset clears all entries, counts, timers, the miss counter and the output pulses.
- R12: Identifiers are handed out at allocation from a counter that starts at 1 after reset and steps by one, skipping 0 on wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Block accepts an operation |
| in_addr | input | 16 | Operation address |
| in_cmd | input | 1 | Command, 0 read, 1 write |
| in_last | input | 1 | Closes the current window after this operation |
| cfg_threshold | input | 8 | Back-to-back repeats needed to learn |
| cfg_min_len | input | 3 | Shortest window that is kept |
| cfg_idle | input | 16 | Idle cycles before eviction, 0 disables |
| learn_valid | output | 1 | One-cycle pulse: an entry became learned |
| learn_id | output | 16 | Identifier of the newly learned entry |
| go_valid | output | 1 | One-cycle pulse: replay may start |
| go_id | output | 16 | Identifier of the learned entry hit |
| miss_count | output | 16 | Candidates dropped on learned slots |

## Verification
The main function is driven with a run of identical windows, which separates learning at exactly the threshold from learning one repeat early or late. An interrupted run shows that the count restarts rather than carrying on. Windows built to collide on a slot, made by flipping two address bits of the first element that cancel in the fold, separate a real comparator from a hash-only hit. When the occupant is learned, they also show the drop-and-count path. Windows with the same opening but a different command, or a different length, separate the prefix trigger from full-sequence equality. Timed gaps between replay hits separate timer refresh from eviction.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } cmd_e;

  localparam int unsigned DEF_THRESHOLD = 5;
endpackage

// File: rtl/rpt_window.sv
module rpt_window #(
  parameter int SEQ_LEN = 4,
  parameter int ADDR_W  = 16,
  parameter int PRE_LEN = 2,
  localparam int EL_W   = ADDR_W + 1,
  localparam int LEN_W  = $clog2(SEQ_LEN + 1),
  localparam int SEQ_W  = SEQ_LEN * EL_W,
  localparam int PRE_W  = PRE_LEN * EL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_fire,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_cmd,
  input  logic              op_last,
  input  logic [LEN_W-1:0]  cfg_min_len,
  output logic              win_done,
  output logic              win_keep,
  output logic [SEQ_W-1:0]  win_seq,
  output logic [LEN_W-1:0]  win_len,
  output logic              pre_valid,
  output logic [PRE_W-1:0]  pre_vec
);
  logic [SEQ_W-1:0] acc;
  logic [SEQ_W-1:0] acc_nxt;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cnt_inc;
  logic [EL_W-1:0]  elem;
  logic             closing;

  assign elem    = {op_cmd, op_addr};
  assign cnt_inc = cnt + LEN_W'(1);
  assign closing = op_fire && (op_last || (cnt == LEN_W'(SEQ_LEN - 1)));

  always_comb begin
    acc_nxt = acc;
    acc_nxt[int'(cnt) * EL_W +: EL_W] = elem;
  end

  assign pre_valid = op_fire && (cnt == LEN_W'(PRE_LEN - 1));
  assign pre_vec   = acc_nxt[PRE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      cnt      <= '0;
      win_done <= 1'b0;
      win_keep <= 1'b0;
      win_seq  <= '0;
      win_len  <= '0;
    end else begin
      win_done <= 1'b0;
      win_keep <= 1'b0;
      if (op_fire) begin
        if (closing) begin
          win_done <= 1'b1;
          win_keep <= (cnt_inc >= cfg_min_len);
          win_seq  <= acc_nxt;
          win_len  <= cnt_inc;
          acc      <= '0;
          cnt      <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt_inc;
        end
      end
    end
  end
endmodule

// File: rtl/rpt_table.sv
module rpt_table #(
  parameter int SEQ_LEN = 4,
  parameter int ADDR_W  = 16,
  parameter int PRE_LEN = 2,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 8,
  parameter int ID_W    = 16,
  parameter int TMR_W   = 16,
  parameter int MISS_W  = 16,
  localparam int EL_W   = ADDR_W + 1,
  localparam int LEN_W  = $clog2(SEQ_LEN + 1),
  localparam int SEQ_W  = SEQ_LEN * EL_W,
  localparam int PRE_W  = PRE_LEN * EL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_done,
  input  logic              win_keep,
  input  logic [SEQ_W-1:0]  win_seq,
  input  logic [LEN_W-1:0]  win_len,
  input  logic              pre_valid,
  input  logic [PRE_W-1:0]  pre_vec,
  input  logic [CNT_W-1:0]  cfg_threshold,
  input  logic [TMR_W-1:0]  cfg_idle,
  output logic              learn_valid,
  output logic [ID_W-1:0]   learn_id,
  output logic              go_valid,
  output logic [ID_W-1:0]   go_id,
  output logic [MISS_W-1:0] miss_count
);
  localparam int KEY_W = LEN_W + SEQ_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NCH   = (KEY_W + IDX_W - 1) / IDX_W;

  function automatic logic [IDX_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [NCH*IDX_W-1:0] pad;
    logic [IDX_W-1:0]     h;
    pad = '0;
    pad[KEY_W-1:0] = k;
    h = '0;
    for (int i = 0; i < NCH; i++) h ^= pad[i*IDX_W +: IDX_W];
    return h;
  endfunction

  logic             ent_v   [DEPTH];
  logic             ent_l   [DEPTH];
  logic [KEY_W-1:0] ent_key [DEPTH];
  logic [CNT_W-1:0] ent_cnt [DEPTH];
  logic [ID_W-1:0]  ent_id  [DEPTH];
  logic [TMR_W-1:0] ent_tmr [DEPTH];

  logic             prev_v;
  logic [KEY_W-1:0] prev_key;
  logic [ID_W-1:0]  next_id;

  // replay-start prefix comparators, one per slot
  logic [DEPTH-1:0] pre_hit;
  for (genvar g = 0; g < DEPTH; g++) begin : g_pre
    assign pre_hit[g] = ent_v[g] && ent_l[g]
                        && (ent_key[g][KEY_W-1 -: LEN_W] >= LEN_W'(PRE_LEN))
                        && (ent_key[g][PRE_W-1:0] == pre_vec);
  end

  logic             hit_any;
  logic [IDX_W-1:0] hit_sel;
  always_comb begin
    hit_any = 1'b0;
    hit_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (pre_hit[i]) begin
        hit_any = 1'b1;
        hit_sel = IDX_W'(i);
      end
    end
  end

  // training lookup on a closed window
  logic [KEY_W-1:0] key;
  logic [IDX_W-1:0] idx;
  logic             occ, same, lrn, consec;
  logic [CNT_W-1:0] thr_eff, cnt_sat, upd_cnt;
  logic             do_hit, do_miss, do_alloc, learn_now;
  logic [ID_W-1:0]  learn_idv;

  always_comb begin
    key       = {win_len, win_seq};
    idx       = fold(key);
    occ       = ent_v[idx];
    same      = (ent_key[idx] == key);
    lrn       = ent_l[idx];
    consec    = prev_v && (prev_key == key);
    thr_eff   = (cfg_threshold == '0) ? CNT_W'(1) : cfg_threshold;
    cnt_sat   = (&ent_cnt[idx]) ? ent_cnt[idx] : ent_cnt[idx] + CNT_W'(1);
    do_hit    = win_keep && occ && same;
    do_miss   = win_keep && occ && !same && lrn;
    do_alloc  = win_keep && !(occ && same) && !do_miss;
    if (do_alloc)  upd_cnt = CNT_W'(1);
    else if (lrn)  upd_cnt = ent_cnt[idx];
    else if (consec) upd_cnt = cnt_sat;
    else           upd_cnt = CNT_W'(1);
    learn_now = (do_alloc || (do_hit && !lrn)) && (upd_cnt >= thr_eff);
    learn_idv = do_alloc ? next_id : ent_id[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_v[i]   <= 1'b0;
        ent_l[i]   <= 1'b0;
        ent_key[i] <= '0;
        ent_cnt[i] <= '0;
        ent_id[i]  <= '0;
        ent_tmr[i] <= '0;
      end
      prev_v      <= 1'b0;
      prev_key    <= '0;
      next_id     <= ID_W'(1);
      miss_count  <= '0;
      learn_valid <= 1'b0;
      learn_id    <= '0;
      go_valid    <= 1'b0;
      go_id       <= '0;
    end else begin
      // idle aging and eviction
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_v[i]) begin
          if ((cfg_idle != '0) &&
              (({1'b0, ent_tmr[i]} + (TMR_W+1)'(1)) >= {1'b0, cfg_idle})) begin
            ent_v[i] <= 1'b0;
            ent_l[i] <= 1'b0;
          end else begin
            ent_tmr[i] <= ent_tmr[i] + TMR_W'(1);
          end
        end
      end

      // replay-start hit
      go_valid <= pre_valid && hit_any;
      go_id    <= (pre_valid && hit_any) ? ent_id[hit_sel] : '0;
      if (pre_valid && hit_any) begin
        ent_tmr[hit_sel] <= '0;
        ent_v[hit_sel]   <= 1'b1;
        ent_l[hit_sel]   <= 1'b1;
      end

      // training update
      if (do_hit) begin
        ent_v[idx]   <= 1'b1;
        ent_tmr[idx] <= '0;
        ent_cnt[idx] <= upd_cnt;
        ent_l[idx]   <= lrn || learn_now;
      end
      if (do_alloc) begin
        ent_v[idx]   <= 1'b1;
        ent_l[idx]   <= learn_now;
        ent_key[idx] <= key;
        ent_cnt[idx] <= upd_cnt;
        ent_id[idx]  <= next_id;
        ent_tmr[idx] <= '0;
        next_id      <= (&next_id) ? ID_W'(1) : next_id + ID_W'(1);
      end
      if (do_miss) miss_count <= miss_count + MISS_W'(1);

      learn_valid <= learn_now;
      learn_id    <= learn_now ? learn_idv : '0;

      if (win_keep) begin
        prev_v   <= 1'b1;
        prev_key <= key;
      end else if (win_done) begin
        prev_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rpt_seq_detector.sv
module rpt_seq_detector #(
  parameter int SEQ_LEN = 4,
  parameter int ADDR_W  = 16,
  parameter int PRE_LEN = 2,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 8,
  parameter int ID_W    = 16,
  parameter int TMR_W   = 16,
  parameter int MISS_W  = 16,
  localparam int EL_W   = ADDR_W + 1,
  localparam int LEN_W  = $clog2(SEQ_LEN + 1),
  localparam int SEQ_W  = SEQ_LEN * EL_W,
  localparam int PRE_W  = PRE_LEN * EL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_cmd,
  input  logic              in_last,
  input  logic [CNT_W-1:0]  cfg_threshold,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [TMR_W-1:0]  cfg_idle,
  output logic              learn_valid,
  output logic [ID_W-1:0]   learn_id,
  output logic              go_valid,
  output logic [ID_W-1:0]   go_id,
  output logic [MISS_W-1:0] miss_count
);
  logic             op_fire;
  logic             win_done;
  logic             win_keep;
  logic [SEQ_W-1:0] win_seq;
  logic [LEN_W-1:0] win_len;
  logic             pre_valid;
  logic [PRE_W-1:0] pre_vec;

  assign in_ready = !rst;
  assign op_fire  = in_valid && in_ready;

  rpt_window #(
    .SEQ_LEN(SEQ_LEN), .ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN)
  ) u_win (
    .clk(clk), .rst(rst),
    .op_fire(op_fire), .op_addr(in_addr), .op_cmd(in_cmd), .op_last(in_last),
    .cfg_min_len(cfg_min_len),
    .win_done(win_done), .win_keep(win_keep), .win_seq(win_seq), .win_len(win_len),
    .pre_valid(pre_valid), .pre_vec(pre_vec)
  );

  rpt_table #(
    .SEQ_LEN(SEQ_LEN), .ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN), .DEPTH(DEPTH),
    .CNT_W(CNT_W), .ID_W(ID_W), .TMR_W(TMR_W), .MISS_W(MISS_W)
  ) u_tab (
    .clk(clk), .rst(rst),
    .win_done(win_done), .win_keep(win_keep), .win_seq(win_seq), .win_len(win_len),
    .pre_valid(pre_valid), .pre_vec(pre_vec),
    .cfg_threshold(cfg_threshold), .cfg_idle(cfg_idle),
    .learn_valid(learn_valid), .learn_id(learn_id),
    .go_valid(go_valid), .go_id(go_id), .miss_count(miss_count)
  );
endmodule

// File: rtl/rpt_chk.sv
module rpt_chk #(
  parameter int ID_W   = 16,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              learn_valid,
  input logic [ID_W-1:0]   learn_id,
  input logic              go_valid,
  input logic [ID_W-1:0]   go_id,
  input logic [MISS_W-1:0] miss_count,
  input logic              win_keep
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_GO_FOLLOWS_OP: assert property (@(posedge clk) disable iff (rst)
    (armed && go_valid) |-> $past(in_valid && in_ready)); // R8

  AST_GO_ID_SET: assert property (@(posedge clk) disable iff (rst)
    go_valid |-> (go_id != '0)); // R8

  AST_LEARN_FOLLOWS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (armed && learn_valid) |-> $past(win_keep)); // R4

  AST_LEARN_ID_SET: assert property (@(posedge clk) disable iff (rst)
    learn_valid |-> (learn_id != '0)); // R12

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && (miss_count != $past(miss_count))) |->
      (miss_count == MISS_W'($past(miss_count) + 1'b1))); // R7

  AST_MISS_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (armed && (miss_count != $past(miss_count))) |-> $past(win_keep)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!learn_valid && !go_valid && miss_count == '0)); // R11
endmodule

bind rpt_seq_detector rpt_chk #(.ID_W(ID_W), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .learn_valid(learn_valid), .learn_id(learn_id),
  .go_valid(go_valid), .go_id(go_id), .miss_count(miss_count),
  .win_keep(win_keep)
);

// File: tb/sim_rpt_seq_detector.sv
`timescale 1ns/1ps
module sim_rpt_seq_detector;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_addr;
  logic        in_cmd;
  logic        in_last;
  logic [7:0]  cfg_threshold;
  logic [2:0]  cfg_min_len;
  logic [15:0] cfg_idle;
  logic        learn_valid;
  logic [15:0] learn_id;
  logic        go_valid;
  logic [15:0] go_id;
  logic [15:0] miss_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rpt_seq_detector u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_last(in_last),
    .cfg_threshold(cfg_threshold), .cfg_min_len(cfg_min_len), .cfg_idle(cfg_idle),
    .learn_valid(learn_valid), .learn_id(learn_id),
    .go_valid(go_valid), .go_id(go_id), .miss_count(miss_count)
  );

  typedef struct packed {
    logic [15:0] base;
    logic        cmd;
    logic [2:0]  len;
    logic [15:0] x0;
    logic        eg;
    logic [15:0] gid;
    logic        el;
    logic [15:0] lid;
    logic [7:0]  miss;
  } vec_t;

  // threshold 3, min length 2, eviction off
  localparam vec_t VEC [18] = '{
    '{16'h0100, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0100, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0100, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b1, 16'd1, 8'd0},
    '{16'h0200, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0200, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0300, 1'b1, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0200, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0200, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd0},
    '{16'h0200, 1'b0, 3'd4, 16'h0, 1'b0, 16'd0, 1'b1, 16'd2, 8'd0},
    '{16'h0100, 1'b0, 3'd4, 16'h0, 1'b1, 16'd1, 1'b0, 16'd0, 8'd0},
    '{16'h0100, 1'b0, 3'd4, 16'h9, 1'b0, 16'd0, 1'b0, 16'd0, 8'd1},
    '{16'h0100, 1'b0, 3'd4, 16'h0, 1'b1, 16'd1, 1'b0, 16'd0, 8'd1},
    '{16'h0300, 1'b1, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd1},
    '{16'h0300, 1'b1, 3'd4, 16'h9, 1'b0, 16'd0, 1'b0, 16'd0, 8'd1},
    '{16'h0300, 1'b1, 3'd4, 16'h9, 1'b0, 16'd0, 1'b0, 16'd0, 8'd1},
    '{16'h0300, 1'b1, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd1},
    '{16'h0300, 1'b1, 3'd4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, 8'd1},
    '{16'h0300, 1'b1, 3'd4, 16'h0, 1'b0, 16'd0, 1'b1, 16'd5, 8'd1}
  };

  function automatic string row_tag(int i);
    if (i < 3)       return "R4";
    else if (i < 9)  return "R5";
    else if (i == 9) return "R8";
    else if (i < 12) return "R7";
    else             return "R6";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      in_addr  = 16'($urandom);
      in_cmd   = 1'($urandom);
      in_last  = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic send_op(input logic [15:0] a, input logic c, input logic l);
    in_valid = 1'b1;
    in_addr  = a;
    in_cmd   = c;
    in_last  = l;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_win(input logic [15:0] base, input logic c, input int len,
                          input logic [15:0] x0, input bit eg, input logic [15:0] gid,
                          input bit el, input logic [15:0] lid, input string tag);
    for (int k = 0; k < len; k++) begin
      logic [15:0] a;
      a = base + 16'(k);
      if (k == 0) a = a ^ x0;
      send_op(a, c, (k == len - 1));
      if (k == 1) begin
        check(go_valid == eg, tag, "go_valid", go_valid, eg);
        if (eg) check(go_id == gid, tag, "go_id", go_id, gid);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(learn_valid == el, tag, "learn_valid", learn_valid, el);
    if (el) check(learn_id == lid, tag, "learn_id", learn_id, lid);
    idle(3);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_cmd = 1'b0; in_last = 1'b0;
    cfg_threshold = 8'd3; cfg_min_len = 3'd2; cfg_idle = 16'd0;
    @(negedge clk);
    do_reset();
    // R1 / R11: state after reset
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    check(learn_valid == 1'b0, "R11", "learn_valid", learn_valid, 0);
    check(go_valid == 1'b0, "R11", "go_valid", go_valid, 0);
    check(miss_count == 16'd0, "R11", "miss_count", miss_count, 0);

    // table walk; idle gaps with random data also exercise R1
    for (int i = 0; i < 18; i++) begin
      send_win(VEC[i].base, VEC[i].cmd, int'(VEC[i].len), VEC[i].x0,
               VEC[i].eg, VEC[i].gid, VEC[i].el, VEC[i].lid, row_tag(i));
      check(miss_count == 16'(VEC[i].miss), row_tag(i), "miss_count",
            miss_count, VEC[i].miss);
    end

    // R11 then R2 and R3
    cfg_threshold = 8'd2; cfg_min_len = 3'd3;
    do_reset();
    send_win(16'h0100, 1'b0, 4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, "R11");
    check(miss_count == 16'd0, "R11", "miss_count after reset", miss_count, 0);
    send_win(16'h0500, 1'b0, 2, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, "R2");
    send_win(16'h0100, 1'b0, 4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, "R2");
    send_win(16'h0100, 1'b0, 4, 16'h0, 1'b0, 16'd0, 1'b1, 16'd1, "R2");
    send_win(16'h0100, 1'b1, 4, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, "R3");
    send_win(16'h0100, 1'b0, 3, 16'h0, 1'b1, 16'd1, 1'b0, 16'd0, "R3");
    check(miss_count == 16'd1, "R3", "miss_count for shorter window", miss_count, 1);

    // R9 / R10 idle eviction
    cfg_threshold = 8'd1; cfg_min_len = 3'd3; cfg_idle = 16'd40;
    do_reset();
    send_win(16'h0700, 1'b0, 4, 16'h0, 1'b0, 16'd0, 1'b1, 16'd1, "R9");
    idle(22);
    send_win(16'h0700, 1'b0, 2, 16'h0, 1'b1, 16'd1, 1'b0, 16'd0, "R10");
    idle(22);
    send_win(16'h0700, 1'b0, 2, 16'h0, 1'b1, 16'd1, 1'b0, 16'd0, "R10");
    idle(60);
    send_win(16'h0700, 1'b0, 2, 16'h0, 1'b0, 16'd0, 1'b0, 16'd0, "R9");
    send_win(16'h0700, 1'b0, 4, 16'h0, 1'b0, 16'd0, 1'b1, 16'd2, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule